// File: doc/BRIEF.md
# Interprocessor Token Mailbox

This block is one signaling channel between processors that share a board or a die. One or more sending buses deposit a token (a small code word) into the token register owned by a receiving processor. Storing the token raises the receiver's interrupt line in the same clock edge. The receiver answers the interrupt by reading the token, and that read drops the interrupt again. A complete signaling exchange is one write followed by one read, so the interrupt flag works as its own acknowledge and no separate clear register is needed.

The read data path models a tri-state driver. It has an output enable that is high only while the receiver is reading, and it returns zero at all other times. When several senders write in the same cycle, a fixed priority picks the winner: the lowest index wins. Each losing sender receives a one-cycle retry pulse so that it can try the write again. If a token is overwritten before the receiver has read it, a sticky overrun flag records the loss until the next read.

Top module: `signal_mailbox`

## Requirements
- R1: The stored token is TOKEN_W bits wide (8 by default). It is zero after reset and keeps its value until the next accepted write replaces it.
- R2: An accepted write asserts rcv_irq on the clock edge that stores the token.
- R3: A read with no write in the same cycle clears rcv_irq on that clock edge.
- R4: rcv_rd_oe is high in exactly the cycles in which rcv_rd_en is high. rcv_rd_data then equals the stored token; otherwise rcv_rd_data is all zeros.
- R5: When a write and a read occur in the same cycle, the read returns the old token, the new token is stored, and rcv_irq stays high.
- R6: A write while rcv_irq is high and no read is in progress sets rcv_overrun. The flag stays high through further cycles until a read.
- R7: A read clears rcv_overrun on its clock edge. This includes a read that coincides with a write.
- R8: When several senders write in the same cycle, the sender with the lowest index wins. Sender i's data is stored only if no sender with a lower index writes in that cycle.
- R9: snd_retry[i] is high for exactly the one cycle after a cycle in which sender i wrote and lost arbitration. snd_retry[0] is never high.
- R10: During and right after reset, rcv_irq, rcv_overrun and snd_retry are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snd_wr_en | input | NUM_SENDERS | Per-sender token write strobe |
| snd_wr_data | input | NUM_SENDERS*TOKEN_W | Per-sender token, sender i in bits [i*TOKEN_W +: TOKEN_W] |
| snd_retry | output | NUM_SENDERS | One-cycle pulse telling a sender that lost arbitration to retry |
| rcv_rd_en | input | 1 | Receiver token read strobe |
| rcv_rd_data | output | TOKEN_W | Token driven toward the receiver bus, zero when not reading |
| rcv_rd_oe | output | 1 | Output enable of the modelled tri-state driver |
| rcv_irq | output | 1 | Interrupt line to the receiver |
| rcv_overrun | output | 1 | Sticky flag: a token was overwritten before it was read |

## Verification
The bound checker watches several rules on every clock: that any write raises the interrupt, that a lone read drops it, that the token holds when nobody writes, that the driver is enabled only during reads, and that overrun and retry follow the writes that cause them. Other behaviour can only be shown by the bench's scenarios. These are which sender's data actually ends up in the register, that a coinciding read returns the old token, and the exact values returned on the read path. The bench sweeps every pair of consecutive input combinations of two senders and the reader, and compares against a model it computes itself.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef struct packed {
    logic irq;
    logic ovr;
  } mbx_flags_t;

  // Next interrupt/overrun state for one clock edge.
  // A write always wins the interrupt; a read alone clears both flags;
  // a write onto an unread token without a read marks an overrun.
  function automatic mbx_flags_t mbx_next_flags(mbx_flags_t cur, logic wr, logic rd);
    mbx_flags_t nx;
    nx = cur;
    if (wr) begin
      nx.irq = 1'b1;
      if (rd)           nx.ovr = 1'b0;
      else if (cur.irq) nx.ovr = 1'b1;
    end else if (rd) begin
      nx.irq = 1'b0;
      nx.ovr = 1'b0;
    end
    return nx;
  endfunction

  // Read path value: token while enabled, zeros otherwise.
  function automatic logic mbx_drive_bit(logic oe, logic tok_bit);
    return oe & tok_bit;
  endfunction

endpackage

// File: rtl/mbx_arbiter.sv
module mbx_arbiter #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic [N-1:0] retry_q
);

  logic [N-1:0] lose;

  for (genvar i = 0; i < N; i++) begin : g_prio
    if (i == 0) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_low
      assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  assign lose = req & ~grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) retry_q <= '0;
    else        retry_q <= lose;
  end

endmodule

// File: rtl/mbx_token_reg.sv
module mbx_token_reg
  import mbx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] tok_q,
  output logic         irq_q,
  output logic         ovr_q
);

  mbx_flags_t flags_q;
  mbx_flags_t flags_d;

  always_comb flags_d = mbx_next_flags(flags_q, wr_en, rd_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q   <= '0;
      flags_q <= '0;
    end else begin
      if (wr_en) tok_q <= wr_data;
      flags_q <= flags_d;
    end
  end

  assign irq_q = flags_q.irq;
  assign ovr_q = flags_q.ovr;

endmodule

// File: rtl/mbx_read_port.sv
module mbx_read_port
  import mbx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rd_en,
  input  logic [W-1:0] tok,
  output logic [W-1:0] rd_data,
  output logic         rd_oe
);

  assign rd_oe = rd_en;

  for (genvar b = 0; b < W; b++) begin : g_drv
    assign rd_data[b] = mbx_drive_bit(rd_en, tok[b]);
  end

endmodule

// File: rtl/signal_mailbox.sv
module signal_mailbox #(
  parameter int TOKEN_W     = 8,
  parameter int NUM_SENDERS = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SENDERS-1:0]         snd_wr_en,
  input  logic [NUM_SENDERS*TOKEN_W-1:0] snd_wr_data,
  output logic [NUM_SENDERS-1:0]         snd_retry,
  input  logic                           rcv_rd_en,
  output logic [TOKEN_W-1:0]             rcv_rd_data,
  output logic                           rcv_rd_oe,
  output logic                           rcv_irq,
  output logic                           rcv_overrun
);

  localparam int DATA_W = NUM_SENDERS * TOKEN_W;

  logic [NUM_SENDERS-1:0] grant;
  logic                   wr_any;
  logic [TOKEN_W-1:0]     wr_win_data;
  logic [TOKEN_W-1:0]     token_q;

  mbx_arbiter #(.N(NUM_SENDERS)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (snd_wr_en),
    .grant   (grant),
    .retry_q (snd_retry)
  );

  assign wr_any = |grant;

  always_comb begin
    wr_win_data = '0;
    for (int i = 0; i < NUM_SENDERS; i++) begin
      if (grant[i]) wr_win_data = wr_win_data | snd_wr_data[i*TOKEN_W +: TOKEN_W];
    end
  end

  mbx_token_reg #(.W(TOKEN_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_any),
    .wr_data (wr_win_data),
    .rd_en   (rcv_rd_en),
    .tok_q   (token_q),
    .irq_q   (rcv_irq),
    .ovr_q   (rcv_overrun)
  );

  mbx_read_port #(.W(TOKEN_W)) u_rd (
    .rd_en   (rcv_rd_en),
    .tok     (token_q),
    .rd_data (rcv_rd_data),
    .rd_oe   (rcv_rd_oe)
  );

  logic [DATA_W-1:0] unused_width_probe;
  assign unused_width_probe = snd_wr_data;

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int N = 2,
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] snd_wr_en,
  input logic [N-1:0] snd_retry,
  input logic         rcv_rd_en,
  input logic         rcv_rd_oe,
  input logic [W-1:0] rcv_rd_data,
  input logic         rcv_irq,
  input logic         rcv_overrun,
  input logic [W-1:0] token_q,
  input logic         wr_any
);

  AST_WRITE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|snd_wr_en) |=> rcv_irq); // R2

  AST_LONE_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_rd_en && !(|snd_wr_en)) |=> !rcv_irq); // R3

  AST_TOKEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> $stable(token_q)); // R1

  AST_OE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rcv_rd_en |-> (!rcv_rd_oe && rcv_rd_data == '0)); // R4

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((|snd_wr_en) && rcv_irq && !rcv_rd_en) |=> rcv_overrun); // R6

  AST_OVERRUN_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_rd_en |=> !rcv_overrun); // R7

  AST_OVERRUN_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_overrun |-> rcv_irq); // R6

  AST_TOP_NEVER_RETRIES: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_retry[0]); // R9

  AST_RETRY_FOLLOWS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_wr_en[0] && snd_wr_en[N-1]) |=> snd_retry[N-1]); // R9

  AST_RETRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_retry[N-1] && !(snd_wr_en[0] && snd_wr_en[N-1])) |=> !snd_retry[N-1]); // R9

endmodule

bind signal_mailbox mbx_checker #(.N(NUM_SENDERS), .W(TOKEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .snd_wr_en   (snd_wr_en),
  .snd_retry   (snd_retry),
  .rcv_rd_en   (rcv_rd_en),
  .rcv_rd_oe   (rcv_rd_oe),
  .rcv_rd_data (rcv_rd_data),
  .rcv_irq     (rcv_irq),
  .rcv_overrun (rcv_overrun),
  .token_q     (token_q),
  .wr_any      (wr_any)
);

// File: tb/signal_mailbox_tb.sv
`timescale 1ns/1ps
module signal_mailbox_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  snd_wr_en = '0;
  logic [15:0] snd_wr_data = '0;
  logic [1:0]  snd_retry;
  logic        rcv_rd_en = 1'b0;
  logic [7:0]  rcv_rd_data;
  logic        rcv_rd_oe;
  logic        rcv_irq;
  logic        rcv_overrun;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_tok = 8'h00;
  logic       m_irq = 1'b0;
  logic       m_ovr = 1'b0;
  logic       m_rty = 1'b0;

  always #2.5 clk = ~clk;

  signal_mailbox #(.TOKEN_W(8), .NUM_SENDERS(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .snd_wr_en(snd_wr_en), .snd_wr_data(snd_wr_data),
    .snd_retry(snd_retry), .rcv_rd_en(rcv_rd_en), .rcv_rd_data(rcv_rd_data),
    .rcv_rd_oe(rcv_rd_oe), .rcv_irq(rcv_irq), .rcv_overrun(rcv_overrun)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // One cycle: drive at negedge, check read path, clock, check state.
  task automatic step(input logic w0, input logic w1, input logic rd,
                      input logic [7:0] d0, input logic [7:0] d1);
    logic [7:0] old_tok;
    logic       old_irq;
    snd_wr_en   = {w1, w0};
    snd_wr_data = {d1, d0};
    rcv_rd_en   = rd;
    #1;
    chk("R4", "oe", int'(rcv_rd_oe), int'(rd));
    chk("R4", "rd_data", int'(rcv_rd_data), rd ? int'(m_tok) : 0);
    old_tok = m_tok;
    old_irq = m_irq;
    @(posedge clk);
    m_rty = w0 && w1;
    if (w0 || w1) begin
      m_tok = w0 ? d0 : d1;
      if (rd) m_ovr = 1'b0;
      else if (old_irq) m_ovr = 1'b1;
      m_irq = 1'b1;
    end else if (rd) begin
      m_irq = 1'b0;
      m_ovr = 1'b0;
    end
    @(negedge clk);
    if ((w0 || w1) && rd) chk("R5", "irq", int'(rcv_irq), int'(m_irq));
    else if (w0 || w1)    chk("R2", "irq", int'(rcv_irq), int'(m_irq));
    else                  chk("R3", "irq", int'(rcv_irq), int'(m_irq));
    if (rd) chk("R7", "overrun", int'(rcv_overrun), int'(m_ovr));
    else    chk("R6", "overrun", int'(rcv_overrun), int'(m_ovr));
    chk("R9", "retry1", int'(snd_retry[1]), int'(m_rty));
    chk("R9", "retry0", int'(snd_retry[0]), 0);
    // Token observed through a separate read in the model's view: peek by
    // a combinational read without clocking (rd_en alone drives the path).
    rcv_rd_en   = 1'b1;
    snd_wr_en   = '0;
    #0.5;
    if (w0 && w1) chk("R8", "winner token", int'(rcv_rd_data), int'(m_tok));
    else          chk("R1", "token", int'(rcv_rd_data), int'(m_tok));
    if (old_tok != m_tok && rd && (w0 || w1))
      chk("R5", "new token stored", int'(rcv_rd_data), int'(m_tok));
    rcv_rd_en = 1'b0;
    #0.5;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "irq in reset", int'(rcv_irq), 0);
    chk("R10", "overrun in reset", int'(rcv_overrun), 0);
    chk("R10", "retry in reset", int'(snd_retry), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "irq after reset", int'(rcv_irq), 0);
    rcv_rd_en = 1'b1;
    #0.5;
    chk("R1", "token after reset", int'(rcv_rd_data), 0);
    rcv_rd_en = 1'b0;
    @(negedge clk);

    // Directed: basic exchange, overrun, priority.
    step(1'b0, 1'b1, 1'b0, 8'h00, 8'h5A);
    step(1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    step(1'b1, 1'b0, 1'b0, 8'hC3, 8'h00);
    step(1'b0, 1'b1, 1'b0, 8'h00, 8'h77);
    step(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    step(1'b1, 1'b1, 1'b1, 8'h11, 8'h22);
    step(1'b0, 1'b0, 1'b1, 8'h00, 8'h00);

    // Sweep every ordered pair of input combinations, twice.
    for (int rep = 0; rep < 2; rep++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          logic [7:0] k;
          k = 8'(rep * 64 + a * 8 + b);
          step(a[0], a[1], a[2], k ^ 8'h3C, ~k);
          step(b[0], b[1], b[2], k + 8'h81, k ^ 8'hE7);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule